// File: doc/BRIEF.md
# Load-Adaptive Current Scaling Regulator

This block sets the current scale used by a stepper motor drive. The scale is a 5-bit value, and it follows a 10-bit mechanical-load reading. Each reading arrives together with a one-cycle valid strobe. A low reading means the motor is under heavy load, so the block raises the current. A high reading means the load is light, so the block lowers the current slowly to save energy. A hysteresis band between the two thresholds leaves the current where it is.

Software sets the following fields:
- the lower threshold code and the band width, both counted in units of 32 reading counts;
- the step size used when raising the current;
- how many light-load readings must arrive before each unit of decrease;
- whether the floor is one half or one quarter of the run current;
- an optional filter that uses only every fourth reading.

A lower threshold code of zero turns regulation off. The scale then simply tracks the run current.

Top module: `load_current_regulator`

## Requirements
- R1: After reset is released, the next clock edge loads `cur_scale` with `run_cur`.
- R2: While `thr_min` is 0, `cur_scale` equals `run_cur` one cycle later on every cycle, whatever the strobes or readings.
- R3: An accepted reading strictly below `thr_min*32` raises the current. A reading equal to `thr_min*32` does not raise it.
- R4: Each raise adds 1, 2, 4 or 8 for `up_code` values 0, 1, 2 and 3.
- R5: A raise never takes `cur_scale` above `run_cur`. The result saturates at `run_cur`.
- R6: A reading at or above `(thr_min+thr_hyst+1)*32` counts as light load. The current drops by exactly 1 on the 32nd, 8th, 2nd or 1st consecutive light-load reading, for `dn_code` values 0, 1, 2 and 3.
- R7: A reading inside the band leaves `cur_scale` unchanged. So does a reading that triggers a raise. Both restart the count of light-load readings.
- R8: A decrease never takes `cur_scale` below the floor. The floor is `run_cur>>1` when `floor_quarter` is 0, and `run_cur>>2` when it is 1.
- R9: While regulation is on, `cur_scale` changes only on clock edges where `meas_valid` is high.
- R10: With `filt_en` high, the first three strobes are ignored and the fourth is used. The pattern then repeats. The phase count restarts whenever `filt_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_valid | input | 1 | One-cycle strobe marking a new load reading |
| meas_value | input | 10 | Load reading; a low value means high load |
| run_cur | input | 5 | Run current, which is the ceiling of the scale |
| thr_min | input | 4 | Lower threshold code in units of 32; 0 turns regulation off |
| thr_hyst | input | 4 | Band width code; the upper threshold is (thr_min+thr_hyst+1)*32 |
| up_code | input | 2 | Raise step select (1, 2, 4, 8) |
| dn_code | input | 2 | Decrease rate select (every 32, 8, 2, 1 readings) |
| floor_quarter | input | 1 | Floor select: 0 gives half of run current, 1 gives a quarter |
| filt_en | input | 1 | Use only every fourth reading |
| cur_scale | output | 5 | Actual current scale |

## Verification
Some internal faults show up on `cur_scale` within one strobe: a wrong threshold compare, a wrong step width or a missing clamp. The wrong value appears on the edge that follows the offending strobe. A fault in the rate counter or the filter phase is different. It stays hidden until its count runs out, which can take up to 32 strobes. Only then does a decrement come early or late, or a reading that should have been skipped change the output. For this reason the tests run full count windows, and they put in-band readings inside a window to show that the count restarts.

// File: rtl/lcr_pkg.sv
package lcr_pkg;

  // Raise step for a 2-bit step code: 1, 2, 4 or 8.
  function automatic logic [3:0] up_step(input logic [1:0] code);
    return 4'b0001 << code;
  endfunction

  // Number of light-load readings needed for one unit of decrease.
  function automatic logic [5:0] dn_period(input logic [1:0] code);
    logic [5:0] p;
    case (code)
      2'd0:    p = 6'd32;
      2'd1:    p = 6'd8;
      2'd2:    p = 6'd2;
      default: p = 6'd1;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/lcr_window.sv
module lcr_window #(
  parameter int MEAS_W  = 10,
  parameter int THR_W   = 4,
  parameter int UNIT_SH = 5
) (
  input  logic [MEAS_W-1:0] meas,
  input  logic [THR_W-1:0]  thr_min,
  input  logic [THR_W-1:0]  thr_hyst,
  output logic              raise,
  output logic              hi_hit
);
  localparam int BND_W = THR_W + UNIT_SH + 2;
  localparam int CMP_W = (BND_W > MEAS_W + 1) ? BND_W : MEAS_W + 1;

  logic [CMP_W-1:0] lo_bound, hi_bound, meas_ext;

  always_comb begin
    meas_ext = CMP_W'(meas);
    lo_bound = CMP_W'(thr_min) << UNIT_SH;
    hi_bound = (CMP_W'(thr_min) + CMP_W'(thr_hyst) + CMP_W'(1)) << UNIT_SH;
    raise    = (meas_ext < lo_bound);
    hi_hit   = (meas_ext >= hi_bound);
  end

endmodule

// File: rtl/lcr_rate.sv
module lcr_rate
  import lcr_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       hi_hit,
  input  logic [1:0] dn_code,
  output logic       fire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   last_idx;
  logic             cnt_en;

  always_comb begin
    last_idx = (CNT_W+1)'(dn_period(dn_code)) - (CNT_W+1)'(1);
    fire     = tick && hi_hit && ({1'b0, cnt_q} >= last_idx);
    cnt_en   = tick;
    if (!hi_hit || fire) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/lcr_filter.sv
module lcr_filter #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic filt_en,
  output logic take
);
  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [PH_W-1:0] ph_q, ph_d;
  logic            ph_wrap;

  always_comb begin
    ph_wrap = (ph_q == PH_W'(DIV - 1));
    take    = valid && (!filt_en || ph_wrap);
    if (!filt_en)   ph_d = '0;
    else if (valid) ph_d = ph_wrap ? '0 : ph_q + 1'b1;
    else            ph_d = ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

endmodule

// File: rtl/load_current_regulator.sv
module load_current_regulator
  import lcr_pkg::*;
#(
  parameter int MEAS_W   = 10,
  parameter int CUR_W    = 5,
  parameter int THR_W    = 4,
  parameter int UNIT_SH  = 5,
  parameter int FILT_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_valid,
  input  logic [MEAS_W-1:0] meas_value,
  input  logic [CUR_W-1:0]  run_cur,
  input  logic [THR_W-1:0]  thr_min,
  input  logic [THR_W-1:0]  thr_hyst,
  input  logic [1:0]        up_code,
  input  logic [1:0]        dn_code,
  input  logic              floor_quarter,
  input  logic              filt_en,
  output logic [CUR_W-1:0]  cur_scale
);
  localparam int SUM_W = CUR_W + 4;
  localparam int RCNT_W = 5;

  logic             loaded_q, regulate, take, raise, hi_hit, dec_fire, tick, reg_en;
  logic [CUR_W-1:0] cur_q, cur_d, floor_lim;
  logic [SUM_W-1:0] up_sum;

  lcr_filter #(.DIV(FILT_DIV)) u_filter (
    .clk(clk), .rst_n(rst_n), .valid(meas_valid), .filt_en(filt_en), .take(take)
  );

  lcr_window #(.MEAS_W(MEAS_W), .THR_W(THR_W), .UNIT_SH(UNIT_SH)) u_window (
    .meas(meas_value), .thr_min(thr_min), .thr_hyst(thr_hyst),
    .raise(raise), .hi_hit(hi_hit)
  );

  lcr_rate #(.CNT_W(RCNT_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hi_hit(hi_hit),
    .dn_code(dn_code), .fire(dec_fire)
  );

  always_comb begin
    regulate  = (thr_min != '0);
    tick      = take && regulate && loaded_q;
    floor_lim = floor_quarter ? (run_cur >> 2) : (run_cur >> 1);
    up_sum    = SUM_W'(cur_q) + SUM_W'(up_step(up_code));
    cur_d     = cur_q;
    if (!loaded_q || !regulate) begin
      cur_d = run_cur;
    end else if (tick && raise) begin
      cur_d = (up_sum > SUM_W'(run_cur)) ? run_cur : up_sum[CUR_W-1:0];
      if (cur_d < floor_lim) cur_d = floor_lim;
    end else if (dec_fire) begin
      cur_d = (cur_q == '0) ? '0 : cur_q - 1'b1;
      if (cur_d > run_cur)   cur_d = run_cur;
      if (cur_d < floor_lim) cur_d = floor_lim;
    end
    reg_en = !loaded_q || !regulate || (tick && (raise || dec_fire));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      cur_q    <= '0;
    end else begin
      loaded_q <= 1'b1;
      if (reg_en) cur_q <= cur_d;
    end
  end

  assign cur_scale = cur_q;

  AST_WINDOW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(raise && hi_hit)); // R3

  AST_OFF_FOLLOWS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(loaded_q && (thr_min == '0)) |-> cur_scale == $past(run_cur)); // R2

  AST_RAISE_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick && raise) |-> cur_scale <= $past(run_cur)); // R5

  AST_DROP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dec_fire) |-> cur_scale >= $past(floor_lim)); // R8

  AST_DROP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(loaded_q) && $past(thr_min != '0) && (cur_scale < $past(cur_scale))
     && ($past(cur_scale) <= $past(run_cur)))
    |-> cur_scale == $past(cur_scale) - 1'b1); // R6

  AST_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick && !raise && !hi_hit) |-> cur_scale == $past(cur_scale)); // R7

  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(loaded_q) && $past(!meas_valid) && $past(thr_min != '0))
    |-> cur_scale == $past(cur_scale)); // R9

endmodule

// File: tb/load_current_regulator_test.sv
module load_current_regulator_test;
  logic       clk;
  logic       rst_n;
  logic       meas_valid;
  logic [9:0] meas_value;
  logic [4:0] run_cur;
  logic [3:0] thr_min, thr_hyst;
  logic [1:0] up_code, dn_code;
  logic       floor_quarter, filt_en;
  logic [4:0] cur_scale;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  load_current_regulator uut (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_value(meas_value),
    .run_cur(run_cur), .thr_min(thr_min), .thr_hyst(thr_hyst),
    .up_code(up_code), .dn_code(dn_code), .floor_quarter(floor_quarter),
    .filt_en(filt_en), .cur_scale(cur_scale)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Defaults: run 24, low bound 128, high bound 224.
  initial begin
    rst_n = 1'b0; meas_valid = 1'b0; meas_value = '0; run_cur = 5'd24;
    thr_min = 4'd4; thr_hyst = 4'd2; up_code = 2'd0; dn_code = 2'd3;
    floor_quarter = 1'b0; filt_en = 1'b0;
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: cur_scale=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; meas_valid = 1'b0; meas_value = '0; run_cur = 5'd24;
    thr_min = 4'd4; thr_hyst = 4'd2; up_code = 2'd0; dn_code = 2'd3;
    floor_quarter = 1'b0; filt_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic strobe(input int m);
    @(negedge clk);
    meas_value = 10'(m);
    meas_valid = 1'b1;
    @(negedge clk);
    meas_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset load", cur_scale, 24);
  endtask

  task automatic t_fast_drop();
    dn_code = 2'd3;
    strobe(224);  check("R6 drop at high bound", cur_scale, 23);
    strobe(1023); check("R6 drop at max reading", cur_scale, 22);
  endtask

  task automatic t_band();
    strobe(223); check("R7 just under high bound holds", cur_scale, 22);
    strobe(128); check("R3 equal to low bound no raise", cur_scale, 22);
  endtask

  task automatic t_rates();
    dn_code = 2'd2;
    strobe(600); check("R6 code2 first", cur_scale, 22);
    strobe(600); check("R6 code2 second", cur_scale, 21);
    strobe(600); strobe(150); strobe(600);
    check("R7 band restarts count", cur_scale, 21);
    strobe(600); check("R7 count after restart", cur_scale, 20);
    dn_code = 2'd1;
    for (int i = 0; i < 7; i++) strobe(700);
    check("R6 code1 seven", cur_scale, 20);
    strobe(700); check("R6 code1 eighth", cur_scale, 19);
    dn_code = 2'd0;
    for (int i = 0; i < 31; i++) strobe(900);
    check("R6 code0 thirty-one", cur_scale, 19);
    strobe(900); check("R6 code0 thirty-second", cur_scale, 18);
  endtask

  task automatic t_raise();
    do_reset();
    dn_code = 2'd3;
    for (int i = 0; i < 8; i++) strobe(500);
    check("R6 eight drops", cur_scale, 16);
    up_code = 2'd0; strobe(127); check("R3 R4 step1", cur_scale, 17);
    up_code = 2'd1; strobe(0);   check("R4 step2", cur_scale, 19);
    up_code = 2'd2; strobe(60);  check("R4 step4", cur_scale, 23);
    up_code = 2'd3; strobe(10);  check("R5 saturate at run", cur_scale, 24);
    for (int i = 0; i < 10; i++) strobe(500);
    check("R6 ten drops", cur_scale, 14);
    strobe(10); check("R4 step8", cur_scale, 22);
  endtask

  task automatic t_floor();
    do_reset();
    dn_code = 2'd3;
    for (int i = 0; i < 15; i++) strobe(800);
    check("R8 half floor", cur_scale, 12);
    floor_quarter = 1'b1;
    for (int i = 0; i < 10; i++) strobe(800);
    check("R8 quarter floor", cur_scale, 6);
  endtask

  task automatic t_no_strobe();
    meas_value = '0;
    repeat (5) @(negedge clk);
    check("R9 low reading without strobe", cur_scale, 6);
    meas_value = 10'd1000;
    repeat (5) @(negedge clk);
    check("R9 high reading without strobe", cur_scale, 6);
  endtask

  task automatic t_disabled();
    thr_min = 4'd0; run_cur = 5'd20;
    @(negedge clk);
    check("R2 off follows run", cur_scale, 20);
    strobe(1023); check("R2 off ignores reading", cur_scale, 20);
    run_cur = 5'd9;
    @(negedge clk);
    check("R2 off follows new run", cur_scale, 9);
  endtask

  task automatic t_filter();
    do_reset();
    filt_en = 1'b1; dn_code = 2'd3;
    strobe(900); strobe(900); strobe(900);
    check("R10 three skipped", cur_scale, 24);
    strobe(900); check("R10 fourth used", cur_scale, 23);
    strobe(900); strobe(900); strobe(900);
    check("R10 next three skipped", cur_scale, 23);
    strobe(900); check("R10 eighth used", cur_scale, 22);
  endtask

  initial begin
    t_reset();
    t_fast_drop();
    t_band();
    t_rates();
    t_raise();
    t_floor();
    t_no_strobe();
    t_disabled();
    t_filter();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: cur_scale=%0d expected=finished", cur_scale);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule